// File: doc/BRIEF.md
# Two-Way Interleaved Pipeline Buffer

This block is a byte-wide first-in first-out pipeline built from two parallel chains of register stages. A splitter at the entry hands successive accepted words to the two chains in turn, and a merge stage at the exit pulls them back in the same alternating order. The original word order is therefore rebuilt at the output. Each chain is half as deep as a single linear pipeline of the same total stage count, so a word crosses fewer stages.

Every stage, including the splitter and the merge stage, has two storage slots. Each stage can take a word in while it hands another one on in the same cycle. As a result, a freed slot does not have to creep backwards one stage per cycle before new input is accepted. Both ends use valid/ready handshakes: a word moves only in a cycle where valid and ready are both high, and every stage stalls on its own under back-pressure.

The parameter `STAGES` is the total stage count. It must be even, and each chain holds `STAGES/2 - 1` middle stages between the splitter and the merge stage.

Top module: `wag_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: After reset, the splitter places the first accepted word into its branch-0 slot and the next one into its branch-1 slot. It keeps alternating strictly, and every accepted word lands in exactly one slot.
- R3: After reset, the merge stage delivers its first word from branch 0 and then alternates strictly between branch 1 and branch 0. Every delivered word comes from exactly one branch.
- R4: The delivered word sequence equals the accepted word sequence, with no loss, duplication or reordering, under any pattern of input gaps and output stalls.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.
- R6: When no accepted word is left undelivered, `out_valid` is 0.
- R7: Once the pipeline is filled, with `in_valid` and `out_ready` held high, the buffer accepts one word and delivers one word in every cycle.
- R8: With `out_ready` held low, the buffer accepts exactly 2*`STAGES` words (16 at the default) and then holds `in_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; empties all stages |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | WIDTH | Incoming word |
| in_ready | output | 1 | Buffer can take a word this cycle |
| out_valid | output | 1 | Buffer offers `out_data` |
| out_data | output | WIDTH | Outgoing word |
| out_ready | input | 1 | Consumer takes the offered word this cycle |

## Verification
Two functions often fall in the same cycle: the splitter taking a new word at the entry while the merge stage hands an older word to the consumer, and a middle stage loading its input slot while it moves the previous word into its output slot. Long runs with both handshakes high, and random mixes of input gaps and output stalls, push every chain through cycles where a word enters, moves and leaves together. A scoreboard judges the outcome by matching each delivered word against the accepted sequence. In parallel, an occupancy count kept from the port handshakes must never exceed the capacity and must never show an offered word while it reads zero.

// File: rtl/wag_pkg.sv
package wag_pkg;
  // Number of middle stages in each branch for a given even total stage count.
  function automatic int unsigned wag_mid_stages(input int unsigned stages);
    return stages / 2 - 1;
  endfunction

  // Words the whole buffer can hold: two slots per stage, both branches,
  // plus the two slots each of the splitter and the merge stage.
  function automatic int unsigned wag_capacity(input int unsigned stages);
    return 4 + 4 * wag_mid_stages(stages);
  endfunction
endpackage

// File: rtl/wag_split.sv
module wag_split #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             a_valid,
  output logic [WIDTH-1:0] a_data,
  input  logic             a_ready,
  output logic             b_valid,
  output logic [WIDTH-1:0] b_data,
  input  logic             b_ready,
  output logic             load_x,
  output logic             load_y
);
  logic [WIDTH-1:0] x_q, y_q;
  logic             xv_q, yv_q;
  logic             wsel_q;   // 0: next word goes to slot x (branch 0)
  logic             accept;

  assign in_ready = wsel_q ? !yv_q : !xv_q;
  assign accept   = in_valid && in_ready;
  assign load_x   = accept && !wsel_q;
  assign load_y   = accept && wsel_q;
  assign a_valid  = xv_q;
  assign a_data   = x_q;
  assign b_valid  = yv_q;
  assign b_data   = y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xv_q   <= 1'b0;
      yv_q   <= 1'b0;
      wsel_q <= 1'b0;
    end else begin
      if (load_x) begin
        x_q  <= in_data;
        xv_q <= 1'b1;
      end else if (xv_q && a_ready) begin
        xv_q <= 1'b0;
      end
      if (load_y) begin
        y_q  <= in_data;
        yv_q <= 1'b1;
      end else if (yv_q && b_ready) begin
        yv_q <= 1'b0;
      end
      if (accept) wsel_q <= !wsel_q;
    end
  end
endmodule

// File: rtl/wag_stage.sv
module wag_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready
);
  logic [WIDTH-1:0] ir_q, or_q;
  logic             iv_q, ov_q;
  logic             out_free, move;

  // The output slot is free now, or it empties this very cycle.
  assign out_free  = !ov_q || out_ready;
  assign move      = iv_q && out_free;
  assign in_ready  = !iv_q || out_free;
  assign out_valid = ov_q;
  assign out_data  = or_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_q <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      if (move) begin
        or_q <= ir_q;
        ov_q <= 1'b1;
      end else if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      if (in_valid && in_ready) begin
        ir_q <= in_data;
        iv_q <= 1'b1;
      end else if (move) begin
        iv_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wag_merge.sv
module wag_merge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [WIDTH-1:0] a_data,
  output logic             a_ready,
  input  logic             b_valid,
  input  logic [WIDTH-1:0] b_data,
  output logic             b_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready,
  output logic             emit_x,
  output logic             emit_y
);
  logic [WIDTH-1:0] x_q, y_q;
  logic             xv_q, yv_q;
  logic             rsel_q;   // 0: next word leaves from slot x (branch 0)
  logic             fire;

  assign a_ready   = !xv_q;
  assign b_ready   = !yv_q;
  assign out_valid = rsel_q ? yv_q : xv_q;
  assign out_data  = rsel_q ? y_q : x_q;
  assign fire      = out_valid && out_ready;
  assign emit_x    = fire && !rsel_q;
  assign emit_y    = fire && rsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xv_q   <= 1'b0;
      yv_q   <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      if (a_valid && a_ready) begin
        x_q  <= a_data;
        xv_q <= 1'b1;
      end else if (emit_x) begin
        xv_q <= 1'b0;
      end
      if (b_valid && b_ready) begin
        y_q  <= b_data;
        yv_q <= 1'b1;
      end else if (emit_y) begin
        yv_q <= 1'b0;
      end
      if (fire) rsel_q <= !rsel_q;
    end
  end
endmodule

// File: rtl/wag_buffer.sv
module wag_buffer #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_ready
);
  import wag_pkg::*;

  localparam int MID = int'(wag_mid_stages(STAGES));

  // Per-branch channels: index 0 leaves the splitter, index MID enters the merge.
  logic [WIDTH-1:0] ch_data  [2][MID+1];
  logic             ch_valid [2][MID+1];
  logic             ch_ready [2][MID+1];

  // Internal events brought out for the checker.
  logic split_load_x, split_load_y;
  logic merge_emit_x, merge_emit_y;

  wag_split #(.WIDTH(WIDTH)) u_split (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .a_valid  (ch_valid[0][0]),
    .a_data   (ch_data[0][0]),
    .a_ready  (ch_ready[0][0]),
    .b_valid  (ch_valid[1][0]),
    .b_data   (ch_data[1][0]),
    .b_ready  (ch_ready[1][0]),
    .load_x   (split_load_x),
    .load_y   (split_load_y)
  );

  for (genvar g = 0; g < 2; g++) begin : g_branch
    for (genvar k = 0; k < MID; k++) begin : g_stage
      wag_stage #(.WIDTH(WIDTH)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ch_valid[g][k]),
        .in_data   (ch_data[g][k]),
        .in_ready  (ch_ready[g][k]),
        .out_valid (ch_valid[g][k+1]),
        .out_data  (ch_data[g][k+1]),
        .out_ready (ch_ready[g][k+1])
      );
    end
  end

  wag_merge #(.WIDTH(WIDTH)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .a_valid   (ch_valid[0][MID]),
    .a_data    (ch_data[0][MID]),
    .a_ready   (ch_ready[0][MID]),
    .b_valid   (ch_valid[1][MID]),
    .b_data    (ch_data[1][MID]),
    .b_ready   (ch_ready[1][MID]),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .emit_x    (merge_emit_x),
    .emit_y    (merge_emit_y)
  );
endmodule

// File: rtl/wag_buffer_chk.sv
module wag_buffer_chk #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             split_load_x,
  input logic             split_load_y,
  input logic             merge_emit_x,
  input logic             merge_emit_y
);
  import wag_pkg::*;

  localparam int CAP = int'(wag_capacity(STAGES));
  localparam int CW  = $clog2(CAP + 1) + 1;

  logic          in_fire, out_fire;
  logic [CW-1:0] occ_q;
  logic          ld_next_y_q, em_next_y_q;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q       <= '0;
      ld_next_y_q <= 1'b0;
      em_next_y_q <= 1'b0;
    end else begin
      occ_q <= occ_q + CW'(in_fire) - CW'(out_fire);
      if (split_load_x || split_load_y) ld_next_y_q <= !ld_next_y_q;
      if (merge_emit_x || merge_emit_y) em_next_y_q <= !em_next_y_q;
    end
  end

  AST_SPLIT_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    in_fire |-> $onehot({split_load_x, split_load_y})); // R2
  AST_SPLIT_ALT: assert property (@(posedge clk) disable iff (rst)
    (split_load_x || split_load_y) |-> (split_load_y == ld_next_y_q)); // R2
  AST_MERGE_ONE_SRC: assert property (@(posedge clk) disable iff (rst)
    out_fire |-> $onehot({merge_emit_x, merge_emit_y})); // R3
  AST_MERGE_ALT: assert property (@(posedge clk) disable iff (rst)
    (merge_emit_x || merge_emit_y) |-> (merge_emit_y == em_next_y_q)); // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0) |-> !out_valid); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CW'(CAP)); // R8
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (occ_q == CW'(CAP)) |-> !in_ready); // R8
endmodule

bind wag_buffer wag_buffer_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .split_load_x (split_load_x),
  .split_load_y (split_load_y),
  .merge_emit_x (merge_emit_x),
  .merge_emit_y (merge_emit_y)
);

// File: tb/wag_buffer_test.sv
module wag_buffer_test;
  localparam int WIDTH    = 8;
  localparam int STAGES   = 8;
  localparam int WATCHDOG = 200000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic             out_ready = 1'b0;
  logic             in_ready;
  logic             out_valid;
  logic [WIDTH-1:0] out_data;

  int checks = 0;
  int failures = 0;
  int wr = 0;          // words accepted so far
  int rd = 0;          // words delivered so far
  int outs_win = 0;
  bit prev_stall = 1'b0;
  logic [WIDTH-1:0] prev_data = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wag_buffer #(.WIDTH(WIDTH), .STAGES(STAGES)) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  // Word carried by the n-th accepted transfer.
  function automatic logic [WIDTH-1:0] word_for(input int n);
    return WIDTH'((n * 29 + 7) & 255);
  endfunction

  // Words the buffer can hold: two slots in every stage of both branches.
  function automatic int expected_capacity(input int stages);
    return 2 * stages;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inspect the settled ports just before the coming rising edge.
  task automatic observe();
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R5 hold while stalled",
          int'({out_valid, out_data}), int'({1'b1, prev_data}));
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (in_valid && in_ready) wr++;
    if (out_valid && out_ready) begin
      // R2 R3 R4: order is restored only if split and merge alternate alike
      chk(rd < wr, "R4 no extra word", rd, wr - 1);
      chk(out_data == word_for(rd), "R4 order", int'(out_data), int'(word_for(rd)));
      rd++;
      outs_win++;
    end
  endtask

  task automatic tick(input bit iv, input bit ordy);
    @(negedge clk);
    in_valid  = iv;
    in_data   = word_for(wr);
    out_ready = ordy;
    #1;
    observe();
  endtask

  task automatic random_run(input int n, input int pin, input int pout);
    for (int i = 0; i < n; i++)
      tick(($urandom % 100) < pin, ($urandom % 100) < pout);
  endtask

  initial begin
    #(WATCHDOG * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int acc0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) @(negedge clk);
    #1;
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

    // R8: fill with the output blocked
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0);
    chk(wr == expected_capacity(STAGES), "R8 words accepted", wr, expected_capacity(STAGES));
    chk(!in_ready, "R8 in_ready when full", int'(in_ready), 0);
    chk(out_valid, "R8 out_valid when full", int'(out_valid), 1);

    // R4 R6: drain completely
    for (int i = 0; i < 60; i++) tick(1'b0, 1'b1);
    chk(rd == wr, "R4 all delivered", rd, wr);
    chk(!out_valid, "R6 empty after drain", int'(out_valid), 0);

    // R7: steady streaming, one word per cycle after fill
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
    outs_win = 0;
    acc0 = wr;
    for (int i = 0; i < 32; i++) tick(1'b1, 1'b1);
    chk(outs_win == 32, "R7 delivered per window", outs_win, 32);
    chk(wr - acc0 == 32, "R7 accepted per window", wr - acc0, 32);

    // R4 R5: random gaps and stalls of several mixes
    random_run(3000, 70, 60);
    random_run(1500, 30, 90);
    random_run(1500, 95, 20);
    random_run(1000, 50, 50);

    // R4 R6: final drain
    for (int i = 0; i < 80; i++) tick(1'b0, 1'b1);
    chk(rd == wr, "R4 final all delivered", rd, wr);
    chk(!out_valid, "R6 empty at end", int'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule